// File: doc/BRIEF.md
# Pointer Register Address Generator

This block keeps three 16-bit pointers, each held as a pair of byte-wide registers that live at general register numbers 26 to 31. On every cycle it turns the selected pointer and an access mode into a data-memory byte address. Post-increment and pre-decrement accesses write the stepped pointer back on the clock edge that ends the access cycle. In the same cycle it splits the third pointer into a program-memory word address and a byte-lane select, for constant fetches from code space.

The surrounding core sets the pointer halves through byte writes keyed by register number. It raises a one-cycle strobe together with a pointer select and a mode to perform an access. All three pointer values are exported as outputs. The third pointer's output also serves as the target of an indirect jump. The access path is a plain strobe and has no back-pressure: the block accepts an access in every cycle, so an upstream valid/ready stage would keep its ready signal at 1. The address outputs are combinational from the current pointers and the select and mode inputs. Pointer state changes only on a clock edge.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset all three pointers read 0x0000.
- R2: A byte write with `wr_en` high updates one half on the next clock edge. Register number 26 is the first pointer's low byte, 27 its high byte, 28 and 29 the second pointer's low and high bytes, and 30 and 31 the third pointer's low and high bytes.
- R3: A byte write to any register number below 26 changes no pointer.
- R4: In mode 0 (plain), `data_addr` equals the selected pointer (select 0, 1 and 2 pick the first, second and third pointer), and the pointer keeps its value after a strobe.
- R5: In mode 1 (post-increment), `data_addr` equals the selected pointer, and after a strobe the pointer holds that value plus one.
- R6: In mode 2 (pre-decrement), `data_addr` equals the selected pointer minus one in the same cycle, and after a strobe the pointer holds that address.
- R7: Stepping wraps modulo 2^16, with carry and borrow passing between the bytes: 0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF, 0x00FF+1 gives 0x0100, and 0x0100-1 gives 0x00FF.
- R8: `pm_word_addr` equals bits 15:1 of the third pointer, and `pm_hi_byte` equals its bit 0 (0 selects the low byte, 1 the high byte). This holds whatever the select. A strobe in mode 3 (program fetch) leaves every pointer unchanged.
- R9: When a strobe steps a pointer in the same cycle as a byte write to either half of that pointer, the step wins and the write is dropped. A write to a different pointer in that cycle still takes effect.
- R10: Select value 3 drives `data_addr` to 0x0000, and a strobe with it changes no pointer. Without a strobe no pointer steps.
- R11: `ptr_z` always shows the current third pointer, for use as an indirect jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe; steps the pointer in modes 1 and 2 |
| acc_sel | input | 2 | Pointer select: 0 first, 1 second, 2 third, 3 none |
| acc_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 program fetch |
| wr_en | input | 1 | Byte write enable |
| wr_reg | input | 5 | Register number of the byte write |
| wr_data | input | 8 | Byte written |
| data_addr | output | 16 | Effective data address |
| pm_word_addr | output | 15 | Program-memory word address |
| pm_hi_byte | output | 1 | Byte-lane select in the program word |
| ptr_x | output | 16 | First pointer value |
| ptr_y | output | 16 | Second pointer value |
| ptr_z | output | 16 | Third pointer value |

## Verification
The bench runs a store sequence with post-increment and pre-decrement from 0x0060, which separates using the address before the step from using it after. It drives pointers to 0x00FF, 0x0100, 0xFFFF and 0x0000 to test carry, borrow and wrap across the byte boundary. It also sets odd and even third-pointer values to check the byte-lane split. Collisions of a write with a step on the same pointer and on another pointer show which one wins. A long stretch of random selects, modes and writes, checked against a behavioural model on every cycle, covers the mixtures.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 2 * BYTE_W;
  localparam int REG_W    = 5;
  localparam int N_PTR    = 3;
  localparam int BASE_REG = 26;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_PMFETCH = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/ptr_step.sv
module ptr_step
  import ptr_pkg::*;
#(
  parameter int W = PTR_W
) (
  input  logic [W-1:0] cur,
  input  acc_mode_e    mode,
  output logic [W-1:0] addr,
  output logic [W-1:0] next,
  output logic         bump
);
  logic [W-1:0] plus_one;
  logic [W-1:0] minus_one;

  always_comb begin
    plus_one  = cur + W'(1);
    minus_one = cur - W'(1);
    addr      = (mode == AM_PREDEC) ? minus_one : cur;
    next      = (mode == AM_POSTINC) ? plus_one : minus_one;
    bump      = (mode == AM_POSTINC) || (mode == AM_PREDEC);
  end
endmodule

// File: rtl/ptr_pair.sv
module ptr_pair
  import ptr_pkg::*;
#(
  parameter int BW     = BYTE_W,
  parameter int RW     = REG_W,
  parameter int LO_REG = BASE_REG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_reg,
  input  logic [BW-1:0]   wr_data,
  input  logic            upd_en,
  input  logic [2*BW-1:0] upd_val,
  output logic [2*BW-1:0] val
);
  localparam logic [RW-1:0] LO_ID = RW'(LO_REG);
  localparam logic [RW-1:0] HI_ID = RW'(LO_REG + 1);

  logic hit_lo;
  logic hit_hi;

  assign hit_lo = wr_en && (wr_reg == LO_ID);
  assign hit_hi = wr_en && (wr_reg == HI_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else if (upd_en) begin
      val <= upd_val;
    end else if (hit_lo) begin
      val[BW-1:0] <= wr_data;
    end else if (hit_hi) begin
      val[2*BW-1:BW] <= wr_data;
    end
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_stb,
  input  logic [1:0]         acc_sel,
  input  logic [1:0]         acc_mode,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_reg,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [PTR_W-1:0]   data_addr,
  output logic [PTR_W-2:0]   pm_word_addr,
  output logic               pm_hi_byte,
  output logic [PTR_W-1:0]   ptr_x,
  output logic [PTR_W-1:0]   ptr_y,
  output logic [PTR_W-1:0]   ptr_z
);
  localparam int Z_IDX = N_PTR - 1;

  logic [PTR_W-1:0] ptr_val [N_PTR];
  logic [PTR_W-1:0] sel_val;
  logic             sel_ok;
  logic [PTR_W-1:0] step_addr;
  logic [PTR_W-1:0] step_next;
  logic             step_bump;
  acc_mode_e        mode_e;

  assign mode_e = acc_mode_e'(acc_mode);
  assign sel_ok = (int'(acc_sel) < N_PTR);

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < N_PTR; i++) begin
      if (int'(acc_sel) == i) sel_val = ptr_val[i];
    end
  end

  ptr_step #(.W(PTR_W)) u_step (
    .cur  (sel_val),
    .mode (mode_e),
    .addr (step_addr),
    .next (step_next),
    .bump (step_bump)
  );

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic upd;
    assign upd = acc_stb && step_bump && (int'(acc_sel) == g);
    ptr_pair #(
      .BW     (BYTE_W),
      .RW     (REG_W),
      .LO_REG (BASE_REG + 2 * g)
    ) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_reg  (wr_reg),
      .wr_data (wr_data),
      .upd_en  (upd),
      .upd_val (step_next),
      .val     (ptr_val[g])
    );
  end

  assign data_addr    = sel_ok ? step_addr : '0;
  assign pm_word_addr = ptr_val[Z_IDX][PTR_W-1:1];
  assign pm_hi_byte   = ptr_val[Z_IDX][0];
  assign ptr_x        = ptr_val[0];
  assign ptr_y        = ptr_val[1];
  assign ptr_z        = ptr_val[Z_IDX];
endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_stb,
  input logic [1:0]  acc_sel,
  input logic [1:0]  acc_mode,
  input logic        wr_en,
  input logic [15:0] data_addr,
  input logic [14:0] pm_word_addr,
  input logic        pm_hi_byte,
  input logic [15:0] ptr_x,
  input logic [15:0] ptr_z
);
  a_r5_post_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_mode == 2'd1 && acc_sel == 2'd0) |=> (ptr_x == $past(data_addr) + 16'd1));

  a_r5_post_inc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'd1 && acc_sel == 2'd0) |-> (data_addr == ptr_x));

  a_r6_pre_dec_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'd2 && acc_sel == 2'd0) |-> (data_addr == 16'(ptr_x - 16'd1)));

  a_r6_pre_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_mode == 2'd2 && acc_sel == 2'd0) |=> (ptr_x == $past(data_addr)));

  a_r4_plain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_mode == 2'd0 && acc_sel == 2'd0 && !wr_en) |=> $stable(ptr_x));

  a_r8_pm_split: assert property (@(posedge clk) disable iff (!rst_n)
    ({pm_word_addr, pm_hi_byte} == ptr_z));

  a_r8_pm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_mode == 2'd3 && !wr_en) |=> $stable(ptr_z));

  a_r10_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel == 2'd3) |-> (data_addr == 16'h0000));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_stb      (acc_stb),
  .acc_sel      (acc_sel),
  .acc_mode     (acc_mode),
  .wr_en        (wr_en),
  .data_addr    (data_addr),
  .pm_word_addr (pm_word_addr),
  .pm_hi_byte   (pm_hi_byte),
  .ptr_x        (ptr_x),
  .ptr_z        (ptr_z)
);

// File: tb/test_ptr_addr_gen.sv
module test_ptr_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0;
  logic [1:0]  acc_sel = 2'd0;
  logic [1:0]  acc_mode = 2'd0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_reg = 5'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [15:0] data_addr;
  logic [14:0] pm_word_addr;
  logic        pm_hi_byte;
  logic [15:0] ptr_x, ptr_y, ptr_z;

  int n_chk = 0;
  int n_fail = 0;
  int mdl [3];
  string ptr_tag = "R1";

  always #2.5 clk = ~clk;

  ptr_addr_gen i_ptr_addr_gen (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_sel(acc_sel),
    .acc_mode(acc_mode), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .data_addr(data_addr), .pm_word_addr(pm_word_addr), .pm_hi_byte(pm_hi_byte),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ptrs();
    check({ptr_tag, " ptr_x"}, int'(ptr_x), mdl[0]);
    check({ptr_tag, " ptr_y"}, int'(ptr_y), mdl[1]);
    check({ptr_tag, " ptr_z (R11)"}, int'(ptr_z), mdl[2]);
  endtask

  // One cycle: drive at negedge, check combinational outputs, advance model at posedge.
  task automatic cyc(bit stb, int sel, int mode, bit wen, int wreg, int wdat);
    int nxt [3];
    int exp_addr;
    bit stepped;
    string atag;
    @(negedge clk);
    check_ptrs();
    acc_stb = stb; acc_sel = 2'(sel); acc_mode = 2'(mode);
    wr_en = wen; wr_reg = 5'(wreg); wr_data = 8'(wdat);
    #1;
    if (sel == 3) begin exp_addr = 0; atag = "R10"; end
    else if (mode == 2) begin exp_addr = (mdl[sel] - 1) & 16'hFFFF; atag = "R6"; end
    else begin exp_addr = mdl[sel]; atag = (mode == 1) ? "R5" : "R4"; end
    check({atag, " data_addr"}, int'(data_addr), exp_addr);
    check("R8 pm_word_addr", int'(pm_word_addr), mdl[2] >> 1);
    check("R8 pm_hi_byte", int'(pm_hi_byte), mdl[2] & 1);
    nxt = mdl;
    ptr_tag = "R4";
    if (wen && wreg >= 26 && wreg <= 31) begin
      int p = (wreg - 26) / 2;
      if ((wreg - 26) % 2 == 0) nxt[p] = (nxt[p] & 16'hFF00) | (wdat & 8'hFF);
      else nxt[p] = (nxt[p] & 16'h00FF) | ((wdat & 8'hFF) << 8);
      ptr_tag = "R2";
    end else if (wen) ptr_tag = "R3";
    stepped = stb && sel < 3 && (mode == 1 || mode == 2);
    if (stepped) begin
      nxt[sel] = (mode == 1) ? ((mdl[sel] + 1) & 16'hFFFF) : ((mdl[sel] - 1) & 16'hFFFF);
      ptr_tag = wen ? "R9" : ((mode == 1) ? "R5/R7" : "R6/R7");
    end else if (stb && mode == 3) ptr_tag = "R8";
    else if (sel == 3) ptr_tag = "R10";
    @(posedge clk);
    mdl = nxt;
  endtask

  task automatic set_ptr(int p, int v);
    cyc(0, 3, 0, 1, 26 + 2 * p, v & 8'hFF);
    cyc(0, 3, 0, 1, 27 + 2 * p, (v >> 8) & 8'hFF);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    mdl = '{0, 0, 0};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 reset ptr_x", int'(ptr_x), 0);
    check("R1 reset ptr_y", int'(ptr_y), 0);
    check("R1 reset ptr_z", int'(ptr_z), 0);
    // R2: store sequence from 0x0060
    set_ptr(0, 16'h0060);
    cyc(1, 0, 1, 0, 0, 0);   // post-inc at 0x60 (R5)
    cyc(1, 0, 0, 0, 0, 0);   // plain at 0x61 (R4)
    set_ptr(0, 16'h0063);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 2, 0, 0, 0);   // pre-dec to 0x62 (R6)
    cyc(0, 0, 0, 0, 0, 0);
    // R7: carry, borrow, wrap on each pointer
    set_ptr(1, 16'h00FF); cyc(1, 1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    set_ptr(1, 16'h0100); cyc(1, 1, 2, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    set_ptr(2, 16'hFFFF); cyc(1, 2, 1, 0, 0, 0); cyc(0, 2, 0, 0, 0, 0);
    cyc(1, 2, 2, 0, 0, 0); cyc(0, 2, 0, 0, 0, 0);
    set_ptr(0, 16'h0000); cyc(1, 0, 2, 0, 0, 0); cyc(1, 0, 1, 0, 0, 0);
    // R8: program fetch split, even and odd
    set_ptr(2, 16'h1234); cyc(1, 0, 3, 0, 0, 0);
    set_ptr(2, 16'hABCD); cyc(1, 2, 3, 0, 0, 0); cyc(1, 1, 3, 0, 0, 0);
    // R3: writes to other registers ignored
    cyc(0, 0, 0, 1, 25, 8'h55); cyc(0, 0, 0, 1, 0, 8'hAA); cyc(0, 0, 0, 0, 0, 0);
    // R9: step beats write on same pointer; other pointer write applies
    set_ptr(0, 16'h4000);
    cyc(1, 0, 1, 1, 26, 8'h99); cyc(1, 0, 2, 1, 27, 8'h77);
    cyc(1, 0, 1, 1, 28, 8'h5A); cyc(0, 0, 0, 0, 0, 0);
    // R10: no select and no strobe
    cyc(1, 3, 1, 0, 0, 0); cyc(1, 3, 2, 0, 0, 0); cyc(0, 0, 1, 0, 0, 0); cyc(0, 2, 2, 0, 0, 0);
    // Mixed random traffic against the model
    for (int k = 0; k < 600; k++) begin
      cyc(1'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
          1'($urandom), int'($urandom_range(20, 31)), int'($urandom_range(0, 255)));
    end
    cyc(0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule